// File: doc/BRIEF.md
# Continuous Bus Traffic Detector

This block sits beside a bus controller that drives two redundant serial buses. For each bus it receives the words the decoder has recovered, each tagged as either a control word (command or status) or a data word, together with a per-cycle indication that the bus line carries no signal. From this it decides, separately for each bus, whether that bus is already occupied. The usual cause is a remote terminal that has gone out of control and transmits without end.

When the controller is told to run a message on a given bus, it presents an execute request that names the target bus. The block then reports whether that bus is occupied. If it is, the block suppresses the transmission, raises an interrupt to the subsystem and sets a traffic flag. The subsystem can then retry on the other bus. Choosing that bus is the subsystem's job and is not done here.

Top module: `ctd_traffic_monitor`

## Requirements
- R1: While `rst_n` is low at a clock edge, every output (`bus_active`, `tx_suppress`, `irq`, `traffic_flag`) is 0 after that edge, including the case where a bus was occupied before the reset.
- R2: Bit b of `bus_active` goes to 1 on the clock edge that samples the 33rd data word (`word_ctrl[b]`=0) after a control word (`word_ctrl[b]`=1) on bus b. After 32 such data words it is still 0.
- R3: A data word on a bus with no control word seen since reset or since the last quiet period is not counted.
- R4: A control word restarts the data-word count of its bus from zero. It does not clear a `bus_active` bit that is already set.
- R5: After `line_idle[b]`=1 with `word_vld[b]`=0 on QUIET_CYC consecutive clock edges (default 16), `bus_active[b]` is 0 and the count is void. After QUIET_CYC-1 such edges, nothing has changed.
- R6: A quiet stretch shorter than QUIET_CYC edges does not restart the count. Data words on both sides of it add up.
- R7: One cycle after an edge that samples `exec_req`=1, `tx_suppress` and `irq` are both 1 for one cycle if `bus_active[exec_bus]` was 1 at that edge. Otherwise both are 0. Outside these cycles they are 0.
- R8: `traffic_flag` takes the value of `bus_active[exec_bus]` at each edge with `exec_req`=1 and holds its value at every other edge.
- R9: Traffic on one bus never changes the `bus_active` bit, or the verdict, of the other bus.
- R10: The data count saturates. A stream of hundreds of data words keeps `bus_active` at 1 and never wraps it back to 0.
- R11: The verdict uses the bus state from before the edge at which `exec_req` is sampled. A word sampled at that same edge affects only later requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low terminal reset |
| word_vld | input | NUM_BUS | One-cycle strobe per bus: a decoded word is present |
| word_ctrl | input | NUM_BUS | Type tag per bus: 1 = command/status word, 0 = data word |
| line_idle | input | NUM_BUS | Per bus: no signal on the line this cycle |
| exec_req | input | 1 | Controller is asked to transmit a message |
| exec_bus | input | BUS_W | Index of the target bus of the request |
| bus_active | output | NUM_BUS | Per-bus occupied verdict |
| tx_suppress | output | 1 | One-cycle pulse: block the requested transmission |
| irq | output | 1 | One-cycle interrupt pulse to the subsystem |
| traffic_flag | output | 1 | Continuous-traffic flag, updated on each request |

## Verification
Two events can fall in the same clock edge: the execute request that samples a bus's state, and the data word that would push that bus over the threshold. The bench drives the 33rd data word and the request in the very same cycle. It then checks that `bus_active` rises while the verdict stays clear, because the verdict reads the older state. A second request issued one cycle later must then be suppressed. A similar case, a request issued just as a quiet period ends, is judged against the state that stood before that edge.

// File: rtl/ctd_pkg.sv
// Package: shared types and constants for the continuous traffic detector.
// Assumes: nothing outside itself.
package ctd_pkg;

    // Word type tag carried with each decoded word
    typedef enum logic {
        KIND_DATA = 1'b0,
        KIND_CTRL = 1'b1
    } word_kind_e;

    // Default number of data words that may follow a control word before the bus is occupied
    localparam int DEF_RUN_LIMIT = 32;

    // Default number of idle cycles that make a bus quiet
    localparam int DEF_QUIET_CYC = 16;

    // Width of a bus index for a given bus count, never below one bit
    function automatic int bus_sel_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/ctd_quiet_timer.sv
// Module: ctd_quiet_timer
// Counts consecutive cycles in which one bus line is idle and no word
// arrives. It emits quiet_evt on every cycle from the QUIET_CYC-th such
// cycle on, until a word or line activity resets the count.
// Assumes: line_idle and word_vld are synchronous to clk; QUIET_CYC >= 1.
module ctd_quiet_timer #(
    parameter int QUIET_CYC = ctd_pkg::DEF_QUIET_CYC
) (
    input  logic clk,
    input  logic rst_n,
    input  logic word_vld,
    input  logic line_idle,
    output logic quiet_evt
);

    localparam int IW = (QUIET_CYC > 1) ? $clog2(QUIET_CYC) : 1;
    localparam logic [IW-1:0] LAST = IW'(QUIET_CYC - 1);

    logic [IW-1:0] idle_cnt;
    logic          idle_now;

    // This cycle counts toward quiet only with an idle line and no word
    always_comb begin
        idle_now = line_idle && !word_vld;
    end

    // Quiet fires on the cycle that completes the idle window
    always_comb begin
        quiet_evt = idle_now && (idle_cnt == LAST);
    end

    // Idle-cycle counter, held at its last value once the window is complete
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idle_cnt <= '0;
        end else if (!idle_now) begin
            idle_cnt <= '0;
        end else if (idle_cnt != LAST) begin
            idle_cnt <= idle_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/ctd_run_counter.sv
// Module: ctd_run_counter
// Tracks one bus. A control word arms the counter and restarts it. Each
// later data word adds one, saturating at RUN_LIMIT+1. The data word that
// takes the count past RUN_LIMIT marks the bus active. A quiet event
// disarms the counter and clears the active state.
// Assumes: quiet_evt is never high in a cycle with word_vld high.
module ctd_run_counter #(
    parameter int RUN_LIMIT = ctd_pkg::DEF_RUN_LIMIT
) (
    input  logic clk,
    input  logic rst_n,
    input  logic word_vld,
    input  logic word_ctrl,
    input  logic quiet_evt,
    output logic active
);

    import ctd_pkg::*;

    localparam int CW = $clog2(RUN_LIMIT + 2);
    localparam logic [CW-1:0] LIM = CW'(RUN_LIMIT);
    localparam logic [CW-1:0] TOP = CW'(RUN_LIMIT + 1);

    word_kind_e    kind;
    logic          armed;
    logic [CW-1:0] run_cnt;
    logic          take_ctrl;
    logic          take_data;

    // Decode the type tag and qualify the word strobe
    always_comb begin
        kind      = word_kind_e'(word_ctrl);
        take_ctrl = word_vld && (kind == KIND_CTRL);
        take_data = word_vld && (kind == KIND_DATA) && armed;
    end

    // Arm on a control word, disarm on quiet
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= 1'b0;
        end else if (quiet_evt) begin
            armed <= 1'b0;
        end else if (take_ctrl) begin
            armed <= 1'b1;
        end
    end

    // Saturating count of data words since the last control word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_cnt <= '0;
        end else if (quiet_evt || take_ctrl) begin
            run_cnt <= '0;
        end else if (take_data && (run_cnt != TOP)) begin
            run_cnt <= run_cnt + 1'b1;
        end
    end

    // Active once the run is longer than the limit; cleared only by quiet
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
        end else if (quiet_evt) begin
            active <= 1'b0;
        end else if (take_data && (run_cnt >= LIM)) begin
            active <= 1'b1;
        end
    end

endmodule

// File: rtl/ctd_exec_check.sv
// Module: ctd_exec_check
// On an execute request it reads the active state of the named bus and,
// one cycle later, pulses suppress and interrupt if that bus is occupied.
// It also loads the traffic flag with the verdict.
// Assumes: exec_bus is stable in the request cycle; out-of-range indices read as free.
module ctd_exec_check #(
    parameter int NUM_BUS = 2,
    parameter int BUS_W   = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               exec_req,
    input  logic [BUS_W-1:0]   exec_bus,
    input  logic [NUM_BUS-1:0] bus_active,
    output logic               tx_suppress,
    output logic               irq,
    output logic               traffic_flag
);

    logic target_busy;

    // Select the state of the target bus, guarding unused indices
    always_comb begin
        target_busy = 1'b0;
        for (int i = 0; i < NUM_BUS; i++) begin
            if (exec_bus == BUS_W'(i)) begin
                target_busy = bus_active[i];
            end
        end
    end

    // Suppress pulse for a request aimed at an occupied bus
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_suppress <= 1'b0;
        end else begin
            tx_suppress <= exec_req && target_busy;
        end
    end

    // Interrupt pulse raised together with the suppression
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq <= 1'b0;
        end else begin
            irq <= exec_req && target_busy;
        end
    end

    // Flag follows the verdict of the latest request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            traffic_flag <= 1'b0;
        end else if (exec_req) begin
            traffic_flag <= target_busy;
        end
    end

endmodule

// File: rtl/ctd_traffic_monitor.sv
// Module: ctd_traffic_monitor (top)
// Watches every redundant bus for continuous traffic and judges each
// execute request against the state of its target bus. There is one quiet
// timer and one run counter per bus, and one shared request checker.
// Assumes: the word strobes, tags and idle indications come from decoders
// synchronous to clk.
module ctd_traffic_monitor #(
    parameter int NUM_BUS   = 2,
    parameter int RUN_LIMIT = ctd_pkg::DEF_RUN_LIMIT,
    parameter int QUIET_CYC = ctd_pkg::DEF_QUIET_CYC,
    localparam int BUS_W    = ctd_pkg::bus_sel_w(NUM_BUS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_BUS-1:0] word_vld,
    input  logic [NUM_BUS-1:0] word_ctrl,
    input  logic [NUM_BUS-1:0] line_idle,
    input  logic               exec_req,
    input  logic [BUS_W-1:0]   exec_bus,
    output logic [NUM_BUS-1:0] bus_active,
    output logic               tx_suppress,
    output logic               irq,
    output logic               traffic_flag
);

    logic [NUM_BUS-1:0] quiet_evt;

    // One independent detector per bus
    for (genvar b = 0; b < NUM_BUS; b++) begin : g_bus
        ctd_quiet_timer #(
            .QUIET_CYC (QUIET_CYC)
        ) u_quiet (
            .clk       (clk),
            .rst_n     (rst_n),
            .word_vld  (word_vld[b]),
            .line_idle (line_idle[b]),
            .quiet_evt (quiet_evt[b])
        );

        ctd_run_counter #(
            .RUN_LIMIT (RUN_LIMIT)
        ) u_run (
            .clk       (clk),
            .rst_n     (rst_n),
            .word_vld  (word_vld[b]),
            .word_ctrl (word_ctrl[b]),
            .quiet_evt (quiet_evt[b]),
            .active    (bus_active[b])
        );
    end

    ctd_exec_check #(
        .NUM_BUS (NUM_BUS),
        .BUS_W   (BUS_W)
    ) u_check (
        .clk          (clk),
        .rst_n        (rst_n),
        .exec_req     (exec_req),
        .exec_bus     (exec_bus),
        .bus_active   (bus_active),
        .tx_suppress  (tx_suppress),
        .irq          (irq),
        .traffic_flag (traffic_flag)
    );

endmodule

// File: rtl/ctd_traffic_monitor_chk.sv
// Module: ctd_traffic_monitor_chk
// Checker for the port-level timing rules of ctd_traffic_monitor. It is
// attached to the top by the bind statement at the end of this file.
module ctd_traffic_monitor_chk #(
    parameter int NUM_BUS = 2,
    parameter int BUS_W   = 1
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_BUS-1:0] word_vld,
    input logic [NUM_BUS-1:0] word_ctrl,
    input logic [NUM_BUS-1:0] line_idle,
    input logic               exec_req,
    input logic [BUS_W-1:0]   exec_bus,
    input logic [NUM_BUS-1:0] bus_active,
    input logic               tx_suppress,
    input logic               irq,
    input logic               traffic_flag
);

    for (genvar b = 0; b < NUM_BUS; b++) begin : g_bus_chk
        // R2: a bus turns active only on the edge that takes a data word
        p_rise_needs_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(bus_active[b]) |-> $past(word_vld[b] && !word_ctrl[b]));

        // R5: a bus leaves the active state only on an idle cycle without a word
        p_fall_needs_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(bus_active[b]) |-> $past(line_idle[b] && !word_vld[b]));
    end

    // R7: suppression only ever follows a request
    p_suppress_after_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_suppress |-> $past(exec_req));

    // R7: the verdict matches the state of the target bus at the request edge
    p_verdict_state_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(exec_req) |-> (tx_suppress == $past(bus_active[exec_bus])));

    // R7: the interrupt comes with the suppression
    p_irq_with_suppress_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> tx_suppress);

    // R8: the flag moves only on a request
    p_flag_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(exec_req) |-> $stable(traffic_flag));

    // R8: an interrupt always comes with the flag set
    p_irq_sets_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> traffic_flag);

endmodule

bind ctd_traffic_monitor ctd_traffic_monitor_chk #(
    .NUM_BUS (NUM_BUS),
    .BUS_W   (BUS_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .word_vld     (word_vld),
    .word_ctrl    (word_ctrl),
    .line_idle    (line_idle),
    .exec_req     (exec_req),
    .exec_bus     (exec_bus),
    .bus_active   (bus_active),
    .tx_suppress  (tx_suppress),
    .irq          (irq),
    .traffic_flag (traffic_flag)
);

// File: tb/ctd_traffic_monitor_tb_top.sv
// Directed bench for ctd_traffic_monitor: one task per scenario.
// Inputs change at the falling edge and outputs are sampled there too.
module ctd_traffic_monitor_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NB         = 2;
    localparam int LIMIT      = 32;
    localparam int QUIET      = 16;
    localparam int BW         = 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NB-1:0] word_vld = '0;
    logic [NB-1:0] word_ctrl = '0;
    logic [NB-1:0] line_idle = '0;
    logic          exec_req = 1'b0;
    logic [BW-1:0] exec_bus = '0;
    logic [NB-1:0] bus_active;
    logic          tx_suppress;
    logic          irq;
    logic          traffic_flag;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ctd_traffic_monitor #(
        .NUM_BUS   (NB),
        .RUN_LIMIT (LIMIT),
        .QUIET_CYC (QUIET)
    ) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .word_vld     (word_vld),
        .word_ctrl    (word_ctrl),
        .line_idle    (line_idle),
        .exec_req     (exec_req),
        .exec_bus     (exec_bus),
        .bus_active   (bus_active),
        .tx_suppress  (tx_suppress),
        .irq          (irq),
        .traffic_flag (traffic_flag)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        word_vld = '0; word_ctrl = '0; line_idle = '0; exec_req = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // One word on bus b; the result is visible when the task returns
    task automatic send_word(input int b, input logic ctrl);
        @(negedge clk);
        line_idle[b] = 1'b0;
        word_vld[b]  = 1'b1;
        word_ctrl[b] = ctrl;
        @(negedge clk);
        word_vld[b]  = 1'b0;
        word_ctrl[b] = 1'b0;
    endtask

    task automatic send_data(input int b, input int n);
        for (int i = 0; i < n; i++) send_word(b, 1'b0);
    endtask

    // Line idle for n sampling edges, then active again
    task automatic idle_for(input int b, input int n);
        line_idle[b] = 1'b1;
        repeat (n) @(negedge clk);
        line_idle[b] = 1'b0;
    endtask

    // Request on bus b; suppress/irq are visible when the task returns
    task automatic do_exec(input int b);
        @(negedge clk);
        exec_req = 1'b1;
        exec_bus = BW'(b);
        @(negedge clk);
        exec_req = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 bus_active", int'(bus_active), 0);
        check("R1 tx_suppress", int'(tx_suppress), 0);
        check("R1 irq", int'(irq), 0);
        check("R1 traffic_flag", int'(traffic_flag), 0);
    endtask

    task automatic t_threshold();
        do_reset();
        send_word(0, 1'b1);
        send_data(0, LIMIT);
        check("R2 32 data words: still free", int'(bus_active[0]), 0);
        send_data(0, 1);
        check("R2 33rd data word: active", int'(bus_active[0]), 1);
        check("R9 other bus untouched", int'(bus_active[1]), 0);
        do_exec(0);
        check("R7 suppress on busy bus", int'(tx_suppress), 1);
        check("R7 irq on busy bus", int'(irq), 1);
        check("R8 flag set", int'(traffic_flag), 1);
        @(negedge clk);
        check("R7 suppress is one cycle", int'(tx_suppress), 0);
        check("R7 irq is one cycle", int'(irq), 0);
        repeat (3) @(negedge clk);
        check("R8 flag held without request", int'(traffic_flag), 1);
        do_exec(1);
        check("R9 free bus not suppressed", int'(tx_suppress), 0);
        check("R9 free bus no irq", int'(irq), 0);
        check("R8 flag reloaded clear", int'(traffic_flag), 0);
    endtask

    task automatic t_quiet();
        do_reset();
        send_word(0, 1'b1);
        send_data(0, LIMIT + 1);
        idle_for(0, QUIET - 1);
        check("R5 short of quiet window: still active", int'(bus_active[0]), 1);
        idle_for(0, QUIET);
        check("R5 quiet window clears", int'(bus_active[0]), 0);
        send_data(0, LIMIT + 8);
        check("R3 data without control word ignored", int'(bus_active[0]), 0);
    endtask

    task automatic t_short_gap();
        do_reset();
        send_word(0, 1'b1);
        send_data(0, 20);
        idle_for(0, QUIET - 1);
        send_data(0, 12);
        check("R6 count kept over short gap (32)", int'(bus_active[0]), 0);
        send_data(0, 1);
        check("R6 count kept over short gap (33)", int'(bus_active[0]), 1);
    endtask

    task automatic t_restart_saturate();
        do_reset();
        send_word(0, 1'b1);
        send_data(0, 30);
        send_word(0, 1'b1);
        send_data(0, LIMIT);
        check("R4 control word restarts count", int'(bus_active[0]), 0);
        send_data(0, 1);
        check("R4 count after restart reaches limit", int'(bus_active[0]), 1);
        send_word(0, 1'b1);
        check("R4 control word keeps active", int'(bus_active[0]), 1);
        send_data(0, 300);
        check("R10 long stream stays active", int'(bus_active[0]), 1);
        do_exec(0);
        check("R10 long stream still suppressed", int'(tx_suppress), 1);
    endtask

    task automatic t_coincide();
        do_reset();
        send_word(0, 1'b1);
        send_data(0, LIMIT);
        // 33rd data word and request sampled at the same edge
        @(negedge clk);
        word_vld[0] = 1'b1; word_ctrl[0] = 1'b0;
        exec_req = 1'b1; exec_bus = 1'b0;
        @(negedge clk);
        word_vld[0] = 1'b0; exec_req = 1'b0;
        check("R11 bus becomes active", int'(bus_active[0]), 1);
        check("R11 verdict uses earlier state", int'(tx_suppress), 0);
        check("R11 flag from earlier state", int'(traffic_flag), 0);
        do_exec(0);
        check("R11 next request suppressed", int'(tx_suppress), 1);
    endtask

    task automatic t_bus1();
        do_reset();
        send_word(1, 1'b1);
        send_data(1, LIMIT + 1);
        check("R9 bus1 active alone", int'(bus_active), 2);
        do_exec(0);
        check("R9 bus0 request passes", int'(tx_suppress), 0);
        do_exec(1);
        check("R9 bus1 request suppressed", int'(irq), 1);
        // reset while occupied
        do_reset();
        check("R1 reset clears occupied bus", int'(bus_active), 0);
        check("R1 reset clears flag", int'(traffic_flag), 0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        t_reset();
        t_threshold();
        t_quiet();
        t_short_gap();
        t_restart_saturate();
        t_coincide();
        t_bus1();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule